// File: doc/BRIEF.md
# Direct-Form-I Filter MAC Engine

This block computes one filter output for every accepted input sample, using a single multiply-accumulate step per clock cycle. It runs either as a finite impulse response filter with N taps, or as a recursive filter in direct form I with N feed-forward taps and M feedback taps. Coefficients sit in a coefficient store of N+M words. Past inputs and past outputs are kept in two shift-register histories inside the block. Each finished sum is scaled by a left shift of R bits and clipped to 16-bit signed before it is pushed out.

Software configures the engine with a single parameter write. The write carries a function code, the tap counts N and M, the gain shift R and a run bit. A write with the run bit set starts filtering. A write with the run bit clear stops it and empties both histories. Input samples arrive on a valid/ready stream, and results leave on a second valid/ready stream. The engine stalls without losing state whenever either side is not ready.

Top module: `dfi_mac_engine`

## Requirements
- R1: After reset, `running`, `out_valid` and `sat_flag` are 0 and `in_ready` is 1.
- R2: Function code 8 runs the non-recursive filter. The output is sat(( Σ_{k<N} floor(b_k·x[n-k]/2^15) ) · 2^R), where b_k is the coefficient at address k and x[n] is the newest sample. The feedback count field is ignored in this mode.
- R3: Function code 9 runs the recursive filter. Addresses 0..N-1 hold b_0..b_{N-1} and addresses N..N+M-1 hold a_1..a_M. The sum also adds floor(a_k·y[n-k]/2^15) for k=1..M, where y holds the engine's own saturated outputs.
- R4: A parameter write is taken only if one of these holds: code 8 with 1≤N≤64, or code 9 with 2≤N≤64 and 1≤M≤N-1. Any other write, including an unknown code, is ignored and `running` stays 0. N=64 with M=63 is accepted.
- R5: A valid write with the run bit set starts the engine when it is stopped. While it runs, such writes are ignored. A valid write with the run bit clear stops the engine and clears both histories, the sample count and `sat_flag`.
- R6: An output is produced for an accepted sample only while running, and only once at least N samples have been accepted since the last stop write. Samples accepted while stopped count toward N and enter the history, but produce no output.
- R7: `out_valid` rises exactly N+M clock edges after the edge that accepted the sample.
- R8: Results above 32767 or below -32768 clip to those limits and set `sat_flag`. The flag stays set until a stop write.
- R9: `in_ready` is 0 from the accepting edge until the result is taken. While `out_ready` is 0, `out_valid` and `out_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_func | input | 4 | Function code (8 non-recursive, 9 recursive) |
| cfg_taps | input | 7 | Feed-forward tap count N |
| cfg_fb | input | 7 | Feedback tap count M |
| cfg_gain | input | 3 | Gain shift R |
| cfg_start | input | 1 | Run bit |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient address |
| coef_data | input | 16 | Coefficient value, signed q1.15 |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample, signed q1.15 |
| in_ready | output | 1 | Engine accepts a sample |
| out_valid | output | 1 | Result valid |
| out_data | output | 16 | Result, signed q1.15 |
| out_ready | input | 1 | Consumer takes the result |
| running | output | 1 | Engine is started |
| sat_flag | output | 1 | Sticky clipping indicator |

## Verification
A wrong tap index or a stale history entry corrupts the very next output value. In the recursive mode, the error then feeds back into every later result. A miscounted sample total or sequencer index shows up as an output that appears one sample too early or too late, or `out_valid` rising off its N+M-edge slot. The bench sweeps every small N and M combination against an arithmetic model, so these faults appear in the first affected result. A lost clear or a non-sticky flag shows up in `sat_flag` or in the first output after a stop write.

// File: rtl/dfi_mac_pkg.sv
package dfi_mac_pkg;

    localparam int SMP_W     = 16;
    localparam int ACC_W     = 26;
    localparam int GAIN_BITS = 3;
    localparam int GAIN_W    = ACC_W + (1 << GAIN_BITS) - 1;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [3:0] {
        FN_FIR = 4'd8,
        FN_IIR = 4'd9
    } fn_e;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_MAC,
        PH_OUT
    } phase_e;

    typedef struct packed {
        smp_t val;
        logic clip;
    } sat_t;

    // One product of two q1.15 values, floored back to q.15 scale
    function automatic acc_t mac_term(smp_t c, smp_t d);
        logic signed [2*SMP_W-1:0] p;
        p = c * d;
        return acc_t'(p >>> (SMP_W - 1));
    endfunction

    // Gain shift followed by clipping to the sample range
    function automatic sat_t gain_sat(acc_t a, logic [GAIN_BITS-1:0] r);
        logic signed [GAIN_W-1:0] w;
        logic signed [GAIN_W-1:0] hi;
        logic signed [GAIN_W-1:0] lo;
        sat_t s;
        hi = GAIN_W'(32767);
        lo = GAIN_W'(-32768);
        w  = GAIN_W'(a) <<< r;
        if (w > hi) begin
            s.val  = 16'sh7fff;
            s.clip = 1'b1;
        end else if (w < lo) begin
            s.val  = 16'sh8000;
            s.clip = 1'b1;
        end else begin
            s.val  = w[SMP_W-1:0];
            s.clip = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dfi_mac_cfg.sv
module dfi_mac_cfg
    import dfi_mac_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    parameter int CNT_W    = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_func,
    input  logic [CNT_W-1:0]     cfg_taps,
    input  logic [CNT_W-1:0]     cfg_fb,
    input  logic [GAIN_BITS-1:0] cfg_gain,
    input  logic                 cfg_start,
    output logic                 running,
    output logic [CNT_W-1:0]     taps_n,
    output logic [CNT_W-1:0]     fb_m,
    output logic [GAIN_BITS-1:0] gain_r,
    output logic                 hist_clr
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TAPS);

    logic fir_ok;
    logic iir_ok;
    logic word_ok;

    always_comb begin
        fir_ok  = (cfg_func == FN_FIR) && (cfg_taps != '0) && (cfg_taps <= MAX_C);
        iir_ok  = (cfg_func == FN_IIR) && (cfg_taps >= CNT_W'(2)) && (cfg_taps <= MAX_C)
                  && (cfg_fb != '0) && (cfg_fb < cfg_taps);
        word_ok = fir_ok || iir_ok;
        hist_clr = cfg_we && word_ok && !cfg_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            taps_n  <= CNT_W'(1);
            fb_m    <= '0;
            gain_r  <= '0;
        end else if (cfg_we && word_ok) begin
            if (!cfg_start) begin
                running <= 1'b0;
            end else if (!running) begin
                running <= 1'b1;
                taps_n  <= cfg_taps;
                fb_m    <= iir_ok ? cfg_fb : '0;
                gain_r  <= cfg_gain;
            end
        end
    end

endmodule

// File: rtl/dfi_mac_hist.sv
module dfi_mac_hist
    import dfi_mac_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  smp_t din,
    output smp_t tap [DEPTH]
);

    // Entry 0 is the newest value
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                tap[gi] <= '0;
            end else if (push) begin
                if (gi == 0) begin
                    tap[gi] <= din;
                end else begin
                    tap[gi] <= tap[gi-1];
                end
            end
        end
    end

endmodule

// File: rtl/dfi_mac_coef.sv
module dfi_mac_coef
    import dfi_mac_pkg::*;
#(
    parameter int DEPTH = 127,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  smp_t          wdata,
    input  logic [AW-1:0] raddr,
    output smp_t          rdata
);

    smp_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dfi_mac_core.sv
module dfi_mac_core
    import dfi_mac_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    parameter int CNT_W    = 7,
    parameter int CA_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 running,
    input  logic                 clr,
    input  logic [CNT_W-1:0]     taps_n,
    input  logic [CNT_W-1:0]     fb_m,
    input  logic [GAIN_BITS-1:0] gain_r,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 x_push,
    input  smp_t                 x_tap [MAX_TAPS],
    input  smp_t                 y_tap [MAX_TAPS],
    output logic [CA_W-1:0]      coef_idx,
    input  smp_t                 coef_val,
    output logic                 y_push,
    output smp_t                 y_din,
    output logic                 out_valid,
    output smp_t                 out_data,
    input  logic                 out_ready,
    output logic                 sat_flag
);

    localparam int HW = $clog2(MAX_TAPS);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TAPS);

    phase_e           phase;
    logic [CA_W-1:0]  idx;
    acc_t             acc;
    logic [CNT_W-1:0] fill;
    smp_t             out_q;
    logic             sat_q;

    logic [CNT_W-1:0] fill_nx;
    logic [CA_W-1:0]  last_idx;
    logic             last;
    logic             use_x;
    logic [HW-1:0]    x_idx;
    logic [HW-1:0]    y_idx;
    smp_t             opnd;
    acc_t             acc_nx;
    sat_t             res;

    always_comb begin
        in_ready = (phase == PH_WAIT);
        x_push   = in_valid && in_ready;
        fill_nx  = (fill == MAX_C) ? fill : fill + CNT_W'(1);
        last_idx = CA_W'(taps_n) + CA_W'(fb_m) - CA_W'(1);
        last     = (idx == last_idx);
        use_x    = (idx < CA_W'(taps_n));
        x_idx    = idx[HW-1:0];
        y_idx    = HW'(idx - CA_W'(taps_n));
        opnd     = use_x ? x_tap[x_idx] : y_tap[y_idx];
        coef_idx = idx;
        acc_nx   = acc + mac_term(coef_val, opnd);
        res      = gain_sat(acc_nx, gain_r);
        y_push   = (phase == PH_MAC) && last && running;
        y_din    = res.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WAIT;
            idx   <= '0;
            acc   <= '0;
            fill  <= '0;
            out_q <= '0;
            sat_q <= 1'b0;
        end else begin
            if (x_push) begin
                fill <= fill_nx;
            end
            unique case (phase)
                PH_WAIT: begin
                    if (x_push && running && (fill_nx >= taps_n)) begin
                        phase <= PH_MAC;
                        idx   <= '0;
                        acc   <= '0;
                    end
                end
                PH_MAC: begin
                    acc <= acc_nx;
                    if (last) begin
                        phase <= PH_OUT;
                        out_q <= res.val;
                        sat_q <= sat_q | res.clip;
                    end else begin
                        idx <= idx + CA_W'(1);
                    end
                end
                PH_OUT: begin
                    if (out_ready) begin
                        phase <= PH_WAIT;
                    end
                end
                default: phase <= PH_WAIT;
            endcase
            if (!running) begin
                phase <= PH_WAIT;
            end
            if (clr) begin
                fill  <= '0;
                sat_q <= 1'b0;
            end
        end
    end

    assign out_valid = (phase == PH_OUT) && running;
    assign out_data  = out_q;
    assign sat_flag  = sat_q;

endmodule

// File: rtl/dfi_mac_engine.sv
module dfi_mac_engine
    import dfi_mac_pkg::*;
#(
    parameter  int MAX_TAPS = 64,
    localparam int CNT_W    = $clog2(MAX_TAPS + 1),
    localparam int COEF_D   = 2 * MAX_TAPS - 1,
    localparam int CA_W     = $clog2(2 * MAX_TAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_func,
    input  logic [CNT_W-1:0]  cfg_taps,
    input  logic [CNT_W-1:0]  cfg_fb,
    input  logic [2:0]        cfg_gain,
    input  logic              cfg_start,
    input  logic              coef_we,
    input  logic [CA_W-1:0]   coef_addr,
    input  logic [15:0]       coef_data,
    input  logic              in_valid,
    input  logic [15:0]       in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    output logic              running,
    output logic              sat_flag
);

    logic [CNT_W-1:0]     taps_n;
    logic [CNT_W-1:0]     fb_m;
    logic [GAIN_BITS-1:0] gain_r;
    logic                 hist_clr;
    logic                 x_push;
    logic                 y_push;
    smp_t                 y_din;
    smp_t                 x_tap [MAX_TAPS];
    smp_t                 y_tap [MAX_TAPS];
    logic [CA_W-1:0]      coef_idx;
    smp_t                 coef_val;
    smp_t                 out_s;

    dfi_mac_cfg #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_func (cfg_func),
        .cfg_taps (cfg_taps),
        .cfg_fb   (cfg_fb),
        .cfg_gain (cfg_gain),
        .cfg_start(cfg_start),
        .running  (running),
        .taps_n   (taps_n),
        .fb_m     (fb_m),
        .gain_r   (gain_r),
        .hist_clr (hist_clr)
    );

    dfi_mac_coef #(.DEPTH(COEF_D), .AW(CA_W)) u_coef (
        .clk  (clk),
        .we   (coef_we),
        .waddr(coef_addr),
        .wdata(smp_t'(coef_data)),
        .raddr(coef_idx),
        .rdata(coef_val)
    );

    dfi_mac_hist #(.DEPTH(MAX_TAPS)) u_xhist (
        .clk (clk),
        .rst (rst),
        .clr (hist_clr),
        .push(x_push),
        .din (smp_t'(in_data)),
        .tap (x_tap)
    );

    dfi_mac_hist #(.DEPTH(MAX_TAPS)) u_yhist (
        .clk (clk),
        .rst (rst),
        .clr (hist_clr),
        .push(y_push),
        .din (y_din),
        .tap (y_tap)
    );

    dfi_mac_core #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W), .CA_W(CA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .clr      (hist_clr),
        .taps_n   (taps_n),
        .fb_m     (fb_m),
        .gain_r   (gain_r),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .x_push   (x_push),
        .x_tap    (x_tap),
        .y_tap    (y_tap),
        .coef_idx (coef_idx),
        .coef_val (coef_val),
        .y_push   (y_push),
        .y_din    (y_din),
        .out_valid(out_valid),
        .out_data (out_s),
        .out_ready(out_ready),
        .sat_flag (sat_flag)
    );

    assign out_data = out_s;

endmodule

// File: rtl/dfi_mac_chk.sv
module dfi_mac_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [3:0]  cfg_func,
    input logic        cfg_start,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data,
    input logic        running,
    input logic        sat_flag
);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    in_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> !out_valid);

    // R4
    bad_func_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !running && (cfg_func != 4'd8) && (cfg_func != 4'd9)) |=> !running);

    // R8
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !(cfg_we && !cfg_start)) |=> sat_flag);

endmodule

bind dfi_mac_engine dfi_mac_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_func (cfg_func),
    .cfg_start(cfg_start),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .running  (running),
    .sat_flag (sat_flag)
);

// File: tb/dfi_mac_engine_bench.sv
module dfi_mac_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_func = '0;
    logic [6:0]  cfg_taps = '0;
    logic [6:0]  cfg_fb = '0;
    logic [2:0]  cfg_gain = '0;
    logic        cfg_start = 1'b0;
    logic        coef_we = 1'b0;
    logic [6:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b1;
    logic        running;
    logic        sat_flag;

    dfi_mac_engine #(.MAX_TAPS(MAXT)) u_dfi_mac_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_func(cfg_func),
        .cfg_taps(cfg_taps), .cfg_fb(cfg_fb), .cfg_gain(cfg_gain),
        .cfg_start(cfg_start), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .running(running), .sat_flag(sat_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int mx [MAXT];
    int my [MAXT];
    int mc [2*MAXT];
    int mfill = 0;
    bit mrun = 0;
    int mn = 1, mm = 0, mr = 0;
    bit last_clip;
    string cur_tag = "R2";

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_out(output bit clip);
        longint acc = 0;
        for (int k = 0; k < mn; k++) acc += (longint'(mc[k]) * mx[k]) >>> 15;
        for (int k = 0; k < mm; k++) acc += (longint'(mc[mn+k]) * my[k]) >>> 15;
        acc = acc <<< mr;
        clip = 1'b0;
        if (acc > 32767) begin acc = 32767; clip = 1'b1; end
        if (acc < -32768) begin acc = -32768; clip = 1'b1; end
        return int'(acc);
    endfunction

    function automatic int cgen(int a, int b);
        return ((a * 3571 + b * 977) % 9000) - 4500;
    endfunction

    function automatic int fgen(int a, int b);
        return ((a * 131 + b * 57) % 4000) - 2000;
    endfunction

    function automatic int sgen(int i, int s);
        return ((i * 12345 + s * 678) % 50000) - 25000;
    endfunction

    task automatic cfg_write(int f, int p, int q, int r, bit s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_func = 4'(f); cfg_taps = 7'(p); cfg_fb = 7'(q);
        cfg_gain = 3'(r); cfg_start = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stop_all();
        cfg_write(8, 1, 0, 0, 1'b0);
        mrun = 0; mfill = 0;
        for (int k = 0; k < MAXT; k++) begin mx[k] = 0; my[k] = 0; end
    endtask

    task automatic start_f(int f, int n, int m, int r);
        cfg_write(f, n, m, r, 1'b1);
        mrun = 1; mn = n; mm = (f == 9) ? m : 0; mr = r;
    endtask

    task automatic load_coef(int a, int v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 7'(a); coef_data = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
        mc[a] = v;
    endtask

    task automatic send(int v);
        int cnt;
        int exp;
        cnt = 0;
        while (!in_ready && cnt < 400) begin @(negedge clk); cnt++; end
        in_valid = 1'b1; in_data = 16'(v);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = MAXT - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = v;
        if (mfill < MAXT) mfill++;
        if (mrun && mfill >= mn) begin
            exp = model_out(last_clip);
            cnt = 0;
            while (!out_valid && cnt < 400) begin @(negedge clk); cnt++; end
            // R7 latency of N+M edges
            check(cnt == mn + mm, "R7", "latency", cnt, mn + mm);
            check($signed(out_data) == exp, cur_tag, "output value", $signed(out_data), exp);
            for (int k = MAXT - 1; k > 0; k--) my[k] = my[k-1];
            my[0] = exp;
        end else begin
            repeat (mrun ? mn + mm + 2 : 4) @(negedge clk);
            // R6 no output before N samples or while stopped
            check(!out_valid, "R6", "unexpected output", int'(out_valid), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!running, "R1", "running", int'(running), 0);
        check(!out_valid, "R1", "out_valid", int'(out_valid), 0);
        check(!sat_flag, "R1", "sat_flag", int'(sat_flag), 0);
        check(in_ready, "R1", "in_ready", int'(in_ready), 1);

        // R2 sweep of every non-recursive length up to 8, feedback field ignored
        cur_tag = "R2";
        for (int n = 1; n <= 8; n++) begin
            stop_all();
            for (int k = 0; k < n; k++) load_coef(k, cgen(k, n));
            start_f(8, n, n + 5, n % 3);
            for (int i = 0; i < n + 4; i++) send(sgen(i, n));
        end

        // R3 sweep of recursive shapes N=2..6, M=1..N-1
        cur_tag = "R3";
        for (int n = 2; n <= 6; n++) begin
            for (int m = 1; m < n; m++) begin
                stop_all();
                for (int k = 0; k < n; k++) load_coef(k, cgen(k, n + m));
                for (int k = 0; k < m; k++) load_coef(n + k, fgen(k, m));
                start_f(9, n, m, (n + m) % 3);
                for (int i = 0; i < n + 4; i++) send(sgen(i, n * 7 + m));
            end
        end

        // R4 rejected parameter words
        stop_all();
        cfg_write(5, 4, 1, 0, 1'b1);
        check(!running, "R4", "unknown code", int'(running), 0);
        cfg_write(8, 0, 0, 0, 1'b1);
        check(!running, "R4", "zero taps", int'(running), 0);
        cfg_write(8, 65, 0, 0, 1'b1);
        check(!running, "R4", "too many taps", int'(running), 0);
        cfg_write(9, 4, 0, 0, 1'b1);
        check(!running, "R4", "zero feedback", int'(running), 0);
        cfg_write(9, 4, 4, 0, 1'b1);
        check(!running, "R4", "feedback equal N", int'(running), 0);

        // R6 samples loaded while stopped count toward N
        cur_tag = "R6";
        for (int k = 0; k < 4; k++) load_coef(k, cgen(k, 40));
        for (int i = 0; i < 3; i++) send(sgen(i, 40));
        mn = 4; mm = 0; mr = 0;
        start_f(8, 4, 0, 0);
        check(running, "R5", "start accepted", int'(running), 1);
        send(sgen(3, 40));
        send(sgen(4, 40));

        // R5 start write while running is ignored
        cfg_write(9, 2, 1, 2, 1'b1);
        check(running, "R5", "still running", int'(running), 1);
        cur_tag = "R5";
        send(sgen(5, 40));
        stop_all();
        check(!running, "R5", "stopped", int'(running), 0);
        send(1234);

        // R8 clipping and sticky flag
        cur_tag = "R8";
        load_coef(0, 32767);
        start_f(8, 1, 0, 7);
        send(1000);
        check(sat_flag, "R8", "flag after clip high", int'(sat_flag), 1);
        send(10);
        check(sat_flag, "R8", "flag stays set", int'(sat_flag), 1);
        send(-1000);
        stop_all();
        check(!sat_flag, "R8", "flag cleared by stop", int'(sat_flag), 0);

        // R9 output held while consumer stalls
        load_coef(0, 16384);
        start_f(8, 1, 0, 0);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(2000);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            check(out_valid && $signed(out_data) == 1000, "R9", "held output", $signed(out_data), 1000);
            check(!in_ready, "R9", "in_ready during stall", int'(in_ready), 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", "released", int'(out_valid), 0);
        check(in_ready, "R9", "ready again", int'(in_ready), 1);

        // R4 largest recursive shape N=64, M=63
        stop_all();
        for (int k = 0; k < 64; k++) load_coef(k, cgen(k, 3) / 8);
        for (int k = 0; k < 63; k++) load_coef(64 + k, ((k * 37) % 600) - 300);
        start_f(9, 64, 63, 0);
        check(running, "R4", "max shape accepted", int'(running), 1);
        cur_tag = "R3";
        for (int i = 0; i < 66; i++) send(sgen(i, 9));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule